// File: doc/BRIEF.md
# Serial Receive Byte Queue with Threshold Interrupt

This block is the receive-side character store of a serial port. A receive shift register hands it one character at a time, with a parity-error, framing-error and break flag for each, and the block keeps up to sixteen of them in arrival order. The CPU sees the oldest stored character and a line-status summary: data ready, a sticky overrun flag, the three error flags of the oldest character, and an aggregate bit that is high while any stored character has an error.

A two-bit code selects a fill threshold. While receive interrupts are enabled and the number of stored characters is at or above that threshold, the data-available interrupt is high. When the queue is full, a new character is refused and sets the overrun flag. Clearing the queue-mode enable makes the store behave as a single holding register. Any change of that enable empties the store.

Top module: `uart_rxq`

## Requirements
- R1: In queue mode (`fifo_en`=1) up to 16 characters are stored, and `lsr_dr` is high exactly while at least one is stored.
- R2: `rd_byte` shows the oldest stored character. A `rd_data` pulse removes it, so characters come out in arrival order. A pulse on an empty store has no effect.
- R3: A character offered while the store is at capacity, with no read in the same cycle, is not stored, and the stored contents remain unchanged.
- R4: That refused character sets `lsr_oe`. `lsr_oe` stays high until a `rd_lsr` pulse, and it is 0 after that pulse unless a new overrun happens in the same cycle.
- R5: `trig_sel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 characters. `irq_rda` is high when `rx_ie`=1 and the stored count is at or above the threshold.
- R6: `irq_rda` falls once a read brings the count below the threshold, and it is 0 whenever `rx_ie`=0.
- R7: `lsr_pe`, `lsr_fe` and `lsr_bi` give the parity-error, framing-error and break flags of the oldest stored character, and they are 0 when the store is empty.
- R8: `lsr_eiq` is high while any stored character has at least one error flag, and it clears once no stored character has one.
- R9: With `fifo_en`=0 the capacity is one character and the threshold is 1 for every code. `lsr_eiq` reads 0 in this mode, and a second character without an intervening read overruns.
- R10: A change of `fifo_en` empties the store by the next clock edge.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Strobe: a received character is offered |
| rx_data | input | 8 | Received character |
| rx_pe | input | 1 | Parity error of the offered character |
| rx_fe | input | 1 | Framing error of the offered character |
| rx_bi | input | 1 | Break condition of the offered character |
| rd_data | input | 1 | CPU read of the oldest character |
| rd_lsr | input | 1 | CPU read of line status (clears overrun) |
| trig_sel | input | 2 | Threshold code |
| rx_ie | input | 1 | Data-available interrupt enable |
| fifo_en | input | 1 | Queue mode enable |
| rd_byte | output | 8 | Oldest stored character |
| lsr_dr | output | 1 | Data ready |
| lsr_oe | output | 1 | Overrun, sticky |
| lsr_pe | output | 1 | Parity error of oldest character |
| lsr_fe | output | 1 | Framing error of oldest character |
| lsr_bi | output | 1 | Break of oldest character |
| lsr_eiq | output | 1 | Some stored character has an error |
| irq_rda | output | 1 | Data-available interrupt |

## Verification
The hardest state to reach is an overrun that leaves the stored data intact. It needs the store filled to exactly sixteen characters with no reads in between, and then a further character offered. The bench fills the store with a counting pattern and checks the 14-character interrupt on the way. It then offers a marker byte and drains all sixteen entries, so a dropped, duplicated or overwritten entry shows up in the read-back order. The aggregate error bit is driven by a mixed sequence of clean and flagged characters and is checked as each one is read out.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   parameter int RXQ_DATA_W = 8;

   typedef struct packed {
      logic [RXQ_DATA_W-1:0] data;
      logic                  pe;
      logic                  fe;
      logic                  bi;
   } rxq_entry_t;

   function automatic logic ent_has_err(input rxq_entry_t e);
      return e.pe | e.fe | e.bi;
   endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
   import uart_rxq_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [CW-1:0] cap,
   input  rxq_entry_t    wr_ent,
   output rxq_entry_t    head,
   output logic [CW-1:0] count,
   output logic          accept,
   output logic          overflow,
   output logic          pop_ok
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("uart_rxq_store: DEPTH must be a power of two");
   end

   rxq_entry_t    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          room;

   assign pop_ok   = pop && (count != '0) && !flush;
   assign room     = count < cap;
   assign accept   = push && !flush && (room || pop_ok);
   assign overflow = push && !flush && !accept;
   assign head     = (count != '0) ? mem[rd_ptr] : '0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (accept && (wr_ptr == AW'(i))) mem[i] <= wr_ent;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok) rd_ptr <= rd_ptr + AW'(1);
         count <= count + CW'(accept) - CW'(pop_ok);
      end
   end

   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok && !accept |=> count == $past(count) - CW'(1)); // R2
   AST_REFUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> count == $past(count)); // R3
endmodule

// File: rtl/uart_rxq_trig.sv
module uart_rxq_trig #(
   parameter  int T0      = 1,
   parameter  int T1      = 4,
   parameter  int T2      = 8,
   parameter  int T3      = 14,
   parameter  int DEPTH   = 16,
   parameter  bit REG_OUT = 1'b0,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic          fifo_en,
   input  logic          ie,
   input  logic [CW-1:0] count,
   output logic          irq
);
   if (T0 < 1 || T0 > T1 || T1 > T2 || T2 > T3 || T3 > DEPTH) begin : g_bad_thr
      $error("uart_rxq_trig: thresholds must rise within 1..DEPTH");
   end

   logic [CW-1:0] thr;
   logic          hit;

   always_comb begin
      unique case (sel)
         2'd0:    thr = CW'(T0);
         2'd1:    thr = CW'(T1);
         2'd2:    thr = CW'(T2);
         default: thr = CW'(T3);
      endcase
      if (!fifo_en) thr = CW'(1);
   end

   assign hit = ie && (count >= thr);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= hit;
      end
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/uart_rxq_errtrk.sv
module uart_rxq_errtrk
   import uart_rxq_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          accept,
   input  rxq_entry_t    wr_ent,
   input  logic          pop_ok,
   input  rxq_entry_t    head,
   output logic [CW-1:0] err_cnt
);
   logic inc, dec;

   assign inc = accept && ent_has_err(wr_ent);
   assign dec = pop_ok && ent_has_err(head);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     err_cnt <= '0;
      else if (flush) err_cnt <= '0;
      else            err_cnt <= err_cnt + CW'(inc) - CW'(dec);
   end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter  int DEPTH = 16,
   parameter  int T0    = 1,
   parameter  int T1    = 4,
   parameter  int T2    = 8,
   parameter  int T3    = 14,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_valid,
   input  logic [RXQ_DATA_W-1:0] rx_data,
   input  logic                  rx_pe,
   input  logic                  rx_fe,
   input  logic                  rx_bi,
   input  logic                  rd_data,
   input  logic                  rd_lsr,
   input  logic [1:0]            trig_sel,
   input  logic                  rx_ie,
   input  logic                  fifo_en,
   output logic [RXQ_DATA_W-1:0] rd_byte,
   output logic                  lsr_dr,
   output logic                  lsr_oe,
   output logic                  lsr_pe,
   output logic                  lsr_fe,
   output logic                  lsr_bi,
   output logic                  lsr_eiq,
   output logic                  irq_rda
);
   rxq_entry_t    wr_ent, head;
   logic [CW-1:0] count, err_cnt, cap;
   logic          accept, overflow, pop_ok, flush, mode_q, ovr_q;

   assign wr_ent = '{data: rx_data, pe: rx_pe, fe: rx_fe, bi: rx_bi};
   assign flush  = fifo_en != mode_q;
   assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         mode_q <= fifo_en;
         if (overflow)    ovr_q <= 1'b1;
         else if (rd_lsr) ovr_q <= 1'b0;
      end
   end

   uart_rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_valid), .pop(rd_data),
      .cap(cap), .wr_ent(wr_ent), .head(head), .count(count),
      .accept(accept), .overflow(overflow), .pop_ok(pop_ok)
   );

   uart_rxq_errtrk #(.DEPTH(DEPTH)) u_err (
      .clk(clk), .rst_n(rst_n), .flush(flush), .accept(accept), .wr_ent(wr_ent),
      .pop_ok(pop_ok), .head(head), .err_cnt(err_cnt)
   );

   uart_rxq_trig #(.T0(T0), .T1(T1), .T2(T2), .T3(T3), .DEPTH(DEPTH), .REG_OUT(1'b0)) u_trig (
      .clk(clk), .rst_n(rst_n), .sel(trig_sel), .fifo_en(fifo_en), .ie(rx_ie),
      .count(count), .irq(irq_rda)
   );

   assign rd_byte = head.data;
   assign lsr_dr  = count != '0;
   assign lsr_oe  = ovr_q;
   assign lsr_pe  = head.pe;
   assign lsr_fe  = head.fe;
   assign lsr_bi  = head.bi;
   assign lsr_eiq = fifo_en && (err_cnt != '0);

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> lsr_oe); // R4
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_oe && !rd_lsr |=> lsr_oe); // R4
   AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && !flush && count == CW'(DEPTH) && rx_valid && !rd_data |=> count == CW'(DEPTH)); // R3
   AST_EMPTY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      count == '0 |-> err_cnt == '0); // R8
   AST_ERR_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt <= count); // R8
   AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0); // R10
   AST_NOFIFO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en && !flush |=> count <= CW'(1)); // R9
endmodule

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       rx_valid = 0, rx_pe = 0, rx_fe = 0, rx_bi = 0;
   logic [7:0] rx_data = 8'h00;
   logic       rd_data = 0, rd_lsr = 0, rx_ie = 0, fifo_en = 1;
   logic [1:0] trig_sel = 2'd0;
   logic [7:0] rd_byte;
   logic       lsr_dr, lsr_oe, lsr_pe, lsr_fe, lsr_bi, lsr_eiq, irq_rda;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_rxq u_uart_rxq (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi), .rd_data(rd_data), .rd_lsr(rd_lsr),
      .trig_sel(trig_sel), .rx_ie(rx_ie), .fifo_en(fifo_en), .rd_byte(rd_byte),
      .lsr_dr(lsr_dr), .lsr_oe(lsr_oe), .lsr_pe(lsr_pe), .lsr_fe(lsr_fe),
      .lsr_bi(lsr_bi), .lsr_eiq(lsr_eiq), .irq_rda(irq_rda)
   );

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d, input logic pe = 0, input logic fe = 0,
                       input logic bi = 0);
      rx_valid = 1; rx_data = d; rx_pe = pe; rx_fe = fe; rx_bi = bi;
      @(negedge clk);
      rx_valid = 0; rx_pe = 0; rx_fe = 0; rx_bi = 0;
   endtask

   task automatic pop();
      rd_data = 1;
      @(negedge clk);
      rd_data = 0;
   endtask

   task automatic drain();
      while (lsr_dr) pop();
      rd_lsr = 1;
      @(negedge clk);
      rd_lsr = 0;
   endtask

   task automatic t_reset();
      check("R11 dr", lsr_dr, 0);
      check("R11 oe", lsr_oe, 0);
      check("R11 irq", irq_rda, 0);
      check("R11 eiq", lsr_eiq, 0);
      check("R11 flags", {lsr_pe, lsr_fe, lsr_bi}, 0);
      check("R11 byte", rd_byte, 0);
   endtask

   task automatic t_order();
      pop();
      check("R2 empty read no effect", lsr_dr, 0);
      for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
      check("R1 dr", lsr_dr, 1);
      for (int i = 0; i < 5; i++) begin
         check("R2 order", rd_byte, 8'hA0 + i);
         pop();
      end
      check("R1 dr after drain", lsr_dr, 0);
   endtask

   task automatic t_trigger();
      int thr[4] = '{1, 4, 8, 14};
      rx_ie = 1;
      for (int c = 0; c < 4; c++) begin
         trig_sel = 2'(c);
         for (int i = 0; i < thr[c] - 1; i++) push(8'(i));
         check("R5 below threshold", irq_rda, 0);
         push(8'h55);
         check("R5 at threshold", irq_rda, 1);
         rx_ie = 0;
         @(negedge clk);
         check("R6 disabled", irq_rda, 0);
         rx_ie = 1;
         @(negedge clk);
         pop();
         check("R6 below after read", irq_rda, 0);
         drain();
      end
      rx_ie = 0;
   endtask

   task automatic t_overrun();
      trig_sel = 2'd3; rx_ie = 1;
      for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
      check("R5 code 3 irq", irq_rda, 1);
      check("R4 no overrun at 16", lsr_oe, 0);
      push(8'hEE);
      check("R4 overrun set", lsr_oe, 1);
      @(negedge clk);
      check("R4 overrun sticky", lsr_oe, 1);
      for (int i = 0; i < 16; i++) begin
         check("R3 contents kept", rd_byte, 8'h10 + i);
         pop();
      end
      check("R1 empty after 16", lsr_dr, 0);
      check("R4 still set", lsr_oe, 1);
      rd_lsr = 1;
      @(negedge clk);
      rd_lsr = 0;
      check("R4 cleared by status read", lsr_oe, 0);
      rx_ie = 0;
   endtask

   task automatic t_errors();
      push(8'h01);
      push(8'h02, 1, 0, 0);
      push(8'h03, 0, 1, 1);
      push(8'h04);
      check("R7 head clean", {lsr_pe, lsr_fe, lsr_bi}, 3'b000);
      check("R8 eiq set", lsr_eiq, 1);
      pop();
      check("R7 head pe", {lsr_pe, lsr_fe, lsr_bi}, 3'b100);
      pop();
      check("R7 head fe bi", {lsr_pe, lsr_fe, lsr_bi}, 3'b011);
      check("R8 eiq still", lsr_eiq, 1);
      pop();
      check("R8 eiq cleared", lsr_eiq, 0);
      check("R7 data", rd_byte, 8'h04);
      pop();
      check("R7 empty flags", {lsr_pe, lsr_fe, lsr_bi}, 3'b000);
   endtask

   task automatic t_nofifo();
      push(8'h77);
      fifo_en = 0;
      @(negedge clk);
      @(negedge clk);
      check("R10 flush on mode change", lsr_dr, 0);
      trig_sel = 2'd3; rx_ie = 1;
      push(8'h31, 0, 1, 0);
      check("R9 irq at one", irq_rda, 1);
      check("R9 eiq zero", lsr_eiq, 0);
      check("R9 fe visible", lsr_fe, 1);
      push(8'h32);
      check("R9 second overruns", lsr_oe, 1);
      check("R9 first kept", rd_byte, 8'h31);
      drain();
      rx_ie = 0;
      fifo_en = 1;
      @(negedge clk);
      @(negedge clk);
      push(8'h40, 1);
      check("R8 eiq in queue mode", lsr_eiq, 1);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_order();
      t_trigger();
      t_overrun();
      t_errors();
      t_nofifo();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule